// File: doc/BRIEF.md
# Integer Fan-out Execution Unit

This unit executes the integer, comparison, bit-field split and bitwise operations of a dataflow machine. One operation arrives with two 32-bit operands, a 5-bit opcode and a 24-bit packed destination field. Each result is sent on to one or more consumer slots as a stream of tokens. A token pairs a 6-bit destination slot with a 32-bit value. Secondary results go to slots of their own: the overflow flag, the high half of a product, the remainder and the complement of a comparison.

The unit takes one operation at a time. An operation is accepted when `in_valid` and `in_ready` are both high. The unit then sends its tokens one by one under a valid/ready handshake and becomes ready again after the last one. Add, subtract, multiply, logic, compare and split are worked out in the accepting cycle. Divide runs a restoring divider that produces one quotient bit per cycle before any token leaves. Slot number 0 stands for "no consumer".

Top module: `int_fanout_unit`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0. An operation is accepted on a clock edge with `in_valid` and `in_ready` high. `in_ready` then stays low until every token of that operation has been sent.
- R2: Tokens leave in entry order 1, 2, 3, 4. An entry whose slot is 0 emits no token. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_slot` and `out_data` hold steady.
- R3: Opcode 17 (add) sends a+b to slots D1, D2 and D3, and the signed two's-complement overflow flag (1 or 0) to D4. In the arithmetic/logic layout D1 is `in_dst[5:0]`, D2 is `[11:6]`, D3 is `[17:12]` and D4 is `[23:18]`.
- R4: Opcode 18 (subtract) sends a-b to D1..D3 and the signed overflow flag of that difference to D4.
- R5: Opcode 19 (multiply) takes both operands as unsigned. It sends the low 32 product bits to D1..D3 and the high 32 bits to D4.
- R6: Opcode 20 (divide) is unsigned. It sends the quotient to D1..D3 and the remainder to D4. The first token is offered exactly 32 cycles after the accepting edge. A zero divisor gives a quotient of 0xFFFFFFFF and a remainder equal to the dividend.
- R7: Opcodes 28, 29 and 30 send a AND b, a OR b and a XOR b, respectively, to all four slots D1..D4.
- R8: Opcode 16 (compare) uses this layout: code C1 = `in_dst[2:0]`, slots E1 = `[8:3]` and E2 = `[14:9]`, code C2 = `[17:15]`, slot E3 = `[23:18]`. E1 receives the C1 result (1 or 0), E2 its complement, and E3 the C2 result. Codes 0..7 mean: equal, not equal, signed <, signed <=, signed >, signed >=, unsigned <, unsigned >=.
- R9: Opcode 21 (split) sets b = in_b mod 32. Sub-op k (k = 0, 1, 2) occupies `in_dst[8k+7:8k]`: bits [8k+1:8k] are the selector and bits [8k+7:8k+2] the slot. Selector bit 1 picks the high part (bits 31..b) when set and the low part (bits b-1..0) when clear. Selector bit 0 places that part at the top of the word when set and at the bottom when clear. All other bits are zero. Tokens follow sub-op order.
- R10: Any other opcode is accepted, emits no token, and the unit becomes ready again.
- R11: `out_valid` is never high in a cycle where `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit idle and able to accept |
| in_op | input | 5 | Opcode |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| in_dst | input | 24 | Packed destination / code / selector field |
| out_valid | output | 1 | Token offered |
| out_ready | input | 1 | Consumer takes the token |
| out_slot | output | 6 | Destination slot of the token |
| out_data | output | 32 | Value of the token |

## Verification
The bound checker tests the handshake on every cycle:
- the unit goes busy after each accept;
- no token appears while it is ready;
- no token carries slot 0;
- a stalled token holds steady.

Result values and token order can only be shown by the bench's sweeps, which compare them with arithmetic done in the bench. The sweeps cover:
- operand corner values for every operation, including overflow edges and a zero divisor;
- every compare code;
- every split position and selector;
- opcodes the unit does not support.

The divide latency is also checked only in the bench.

// File: rtl/int_fanout_unit.sv
module int_fanout_unit #(
  parameter int W  = 32,
  parameter int SW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [4:0]    in_op,
  input  logic [W-1:0]  in_a,
  input  logic [W-1:0]  in_b,
  input  logic [4*SW-1:0] in_dst,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [SW-1:0] out_slot,
  output logic [W-1:0]  out_data
);
  localparam int BW = $clog2(W);
  localparam int SUB = SW + 2;
  localparam logic [4:0] OP_CMP = 5'd16, OP_ADD = 5'd17, OP_SUB = 5'd18,
                         OP_MUL = 5'd19, OP_DIV = 5'd20, OP_SPL = 5'd21,
                         OP_AND = 5'd28, OP_OR  = 5'd29, OP_XOR = 5'd30;

  typedef enum logic [1:0] {S_IDLE, S_DIV, S_EMIT} state_t;
  state_t state;

  logic [SW-1:0] slot_q [4];
  logic [W-1:0]  val_q  [4];
  logic [1:0]    idx;
  logic [W-1:0]  dq, dr, dvs;
  logic [BW-1:0] cnt;

  logic [SW-1:0] nslot [4];
  logic [W-1:0]  nval  [4];

  function automatic logic cmp_f(input logic [2:0] c, input logic [W-1:0] a, b);
    case (c)
      3'd0:    cmp_f = (a == b);
      3'd1:    cmp_f = (a != b);
      3'd2:    cmp_f = ($signed(a) <  $signed(b));
      3'd3:    cmp_f = ($signed(a) <= $signed(b));
      3'd4:    cmp_f = ($signed(a) >  $signed(b));
      3'd5:    cmp_f = ($signed(a) >= $signed(b));
      3'd6:    cmp_f = (a < b);
      default: cmp_f = (a >= b);
    endcase
  endfunction

  function automatic logic [W-1:0] split_f(input logic [1:0] sel, input logic [W-1:0] a,
                                           input logic [BW-1:0] sh);
    logic [W-1:0] mask;
    logic [BW:0]  up;
    mask = (W'(1) << sh) - W'(1);
    up   = (BW+1)'(W) - {1'b0, sh};
    case (sel)
      2'b00:   split_f = a & mask;
      2'b01:   split_f = a << up;
      2'b10:   split_f = a >> sh;
      default: split_f = a & ~mask;
    endcase
  endfunction

  logic [W-1:0]   sum, dif;
  logic [2*W-1:0] prod;
  logic           ovf_add, ovf_sub;

  assign sum  = in_a + in_b;
  assign dif  = in_a - in_b;
  assign prod = {{W{1'b0}}, in_a} * {{W{1'b0}}, in_b};
  assign ovf_add = (in_a[W-1] == in_b[W-1]) && (sum[W-1] != in_a[W-1]);
  assign ovf_sub = (in_a[W-1] != in_b[W-1]) && (dif[W-1] != in_a[W-1]);

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      nslot[k] = '0;
      nval[k]  = '0;
    end
    case (in_op)
      OP_ADD, OP_SUB, OP_MUL, OP_DIV, OP_AND, OP_OR, OP_XOR: begin
        for (int k = 0; k < 4; k++) nslot[k] = in_dst[k*SW +: SW];
        case (in_op)
          OP_ADD: begin
            for (int k = 0; k < 3; k++) nval[k] = sum;
            nval[3] = {{(W-1){1'b0}}, ovf_add};
          end
          OP_SUB: begin
            for (int k = 0; k < 3; k++) nval[k] = dif;
            nval[3] = {{(W-1){1'b0}}, ovf_sub};
          end
          OP_MUL: begin
            for (int k = 0; k < 3; k++) nval[k] = prod[W-1:0];
            nval[3] = prod[2*W-1:W];
          end
          OP_AND:  for (int k = 0; k < 4; k++) nval[k] = in_a & in_b;
          OP_OR:   for (int k = 0; k < 4; k++) nval[k] = in_a | in_b;
          OP_XOR:  for (int k = 0; k < 4; k++) nval[k] = in_a ^ in_b;
          default: ;
        endcase
      end
      OP_CMP: begin
        nslot[0] = in_dst[3 +: SW];
        nslot[1] = in_dst[SW+3 +: SW];
        nslot[2] = in_dst[2*SW+6 +: SW];
        nval[0]  = {{(W-1){1'b0}},  cmp_f(in_dst[2:0], in_a, in_b)};
        nval[1]  = {{(W-1){1'b0}}, ~cmp_f(in_dst[2:0], in_a, in_b)};
        nval[2]  = {{(W-1){1'b0}},  cmp_f(in_dst[2*SW+3 +: 3], in_a, in_b)};
      end
      OP_SPL: begin
        for (int k = 0; k < 3; k++) begin
          nslot[k] = in_dst[k*SUB+2 +: SW];
          nval[k]  = split_f(in_dst[k*SUB +: 2], in_a, in_b[BW-1:0]);
        end
      end
      default: ;
    endcase
  end

  logic [W:0]   r_sh;
  logic         ge;
  logic [W-1:0] r_nx, q_nx;

  assign r_sh = {dr, dq[W-1]};
  assign ge   = r_sh >= {1'b0, dvs};
  assign r_nx = ge ? W'(r_sh - {1'b0, dvs}) : r_sh[W-1:0];
  assign q_nx = {dq[W-2:0], ge};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      idx   <= '0;
      dq    <= '0;
      dr    <= '0;
      dvs   <= '0;
      cnt   <= '0;
      for (int k = 0; k < 4; k++) begin
        slot_q[k] <= '0;
        val_q[k]  <= '0;
      end
    end else begin
      case (state)
        S_IDLE: if (in_valid) begin
          for (int k = 0; k < 4; k++) begin
            slot_q[k] <= nslot[k];
            val_q[k]  <= nval[k];
          end
          idx <= '0;
          if (in_op == OP_DIV) begin
            state <= S_DIV;
            dq    <= in_a;
            dr    <= '0;
            dvs   <= in_b;
            cnt   <= '0;
          end else begin
            state <= S_EMIT;
          end
        end
        S_DIV: begin
          dq  <= q_nx;
          dr  <= r_nx;
          cnt <= cnt + BW'(1);
          if (cnt == BW'(W-1)) begin
            for (int k = 0; k < 3; k++) val_q[k] <= q_nx;
            val_q[3] <= r_nx;
            state    <= S_EMIT;
          end
        end
        default: if (slot_q[idx] == '0 || out_ready) begin
          idx <= idx + 2'd1;
          if (idx == 2'd3) state <= S_IDLE;
        end
      endcase
    end
  end

  assign in_ready  = (state == S_IDLE);
  assign out_valid = (state == S_EMIT) && (slot_q[idx] != '0);
  assign out_slot  = slot_q[idx];
  assign out_data  = val_q[idx];
endmodule

// File: rtl/int_fanout_unit_chk.sv
module int_fanout_unit_chk #(
  parameter int W  = 32,
  parameter int SW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [SW-1:0] out_slot,
  input logic [W-1:0]  out_data
);
  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);

  p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_slot) && $stable(out_data));

  p_no_null_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_slot != '0);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);
endmodule

bind int_fanout_unit int_fanout_unit_chk #(.W(W), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_slot(out_slot),
  .out_data(out_data)
);

// File: tb/int_fanout_unit_test.sv
module int_fanout_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, in_valid = 0, out_ready = 0;
  logic [4:0]  in_op = '0;
  logic [31:0] in_a = '0, in_b = '0;
  logic [23:0] in_dst = '0;
  logic        in_ready, out_valid;
  logic [5:0]  out_slot;
  logic [31:0] out_data;

  int n_chk = 0, n_fail = 0, stall_seed = 0;
  bit done = 0;

  int_fanout_unit uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_dst(in_dst), .out_valid(out_valid),
    .out_ready(out_ready), .out_slot(out_slot), .out_data(out_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  logic [31:0] vals [8] = '{32'h0, 32'h1, 32'h2, 32'h7fffffff, 32'h80000000,
                            32'hffffffff, 32'h12345678, 32'h0000ffff};

  logic [5:0]  es [4];
  logic [31:0] ev [4];
  int ne;

  function automatic logic m_cmp(input logic [2:0] c, input logic [31:0] a, b);
    int sa = a, sb = b;
    case (c)
      0: return a == b;
      1: return a != b;
      2: return sa < sb;
      3: return sa <= sb;
      4: return sa > sb;
      5: return sa >= sb;
      6: return a < b;
      default: return a >= b;
    endcase
  endfunction

  function automatic logic [31:0] m_split(input logic [1:0] sel, input logic [31:0] a, input int b);
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) begin
      case (sel)
        2'b00: if (i < b) r[i] = a[i];
        2'b01: if (i < b) r[32-b+i] = a[i];
        2'b10: if (i >= b) r[i-b] = a[i];
        default: if (i >= b) r[i] = a[i];
      endcase
    end
    return r;
  endfunction

  task automatic model(input logic [4:0] op, input logic [31:0] a, b, input logic [23:0] d);
    logic [5:0]  s [4];
    logic [31:0] v [4];
    longint x;
    logic [63:0] p;
    for (int k = 0; k < 4; k++) begin s[k] = d[6*k +: 6]; v[k] = '0; end
    case (op)
      17, 18: begin
        x = (op == 17) ? longint'(int'(a)) + longint'(int'(b)) : longint'(int'(a)) - longint'(int'(b));
        for (int k = 0; k < 3; k++) v[k] = x[31:0];
        v[3] = (x > 64'sd2147483647 || x < -64'sd2147483648) ? 32'd1 : 32'd0;
      end
      19: begin
        p = {32'd0, a} * {32'd0, b};
        for (int k = 0; k < 3; k++) v[k] = p[31:0];
        v[3] = p[63:32];
      end
      20: begin
        for (int k = 0; k < 3; k++) v[k] = (b == 0) ? 32'hffffffff : a / b;
        v[3] = (b == 0) ? a : a % b;
      end
      28: for (int k = 0; k < 4; k++) v[k] = a & b;
      29: for (int k = 0; k < 4; k++) v[k] = a | b;
      30: for (int k = 0; k < 4; k++) v[k] = a ^ b;
      16: begin
        s[0] = d[8:3]; s[1] = d[14:9]; s[2] = d[23:18]; s[3] = 0;
        v[0] = {31'd0, m_cmp(d[2:0], a, b)};
        v[1] = {31'd0, ~m_cmp(d[2:0], a, b)};
        v[2] = {31'd0, m_cmp(d[17:15], a, b)};
      end
      21: begin
        for (int k = 0; k < 3; k++) begin
          s[k] = d[8*k+2 +: 6];
          v[k] = m_split(d[8*k +: 2], a, int'(b % 32));
        end
        s[3] = 0;
      end
      default: for (int k = 0; k < 4; k++) s[k] = 0;
    endcase
    ne = 0;
    for (int k = 0; k < 4; k++) if (s[k] != 0) begin es[ne] = s[k]; ev[ne] = v[k]; ne++; end
  endtask

  task automatic run_op(input logic [4:0] op, input logic [31:0] a, b, input logic [23:0] d,
                        input string req);
    logic [5:0]  gs [8];
    logic [31:0] gv [8];
    int got = 0, first = -1, cyc = 0;
    bit prev_stall = 0, fin = 0;
    logic [5:0]  ps = '0;
    logic [31:0] pv = '0;
    model(op, a, b, d);
    @(negedge clk);
    check(in_ready === 1'b1, "R1", "ready before accept", {31'd0, in_ready}, 32'd1);
    in_op = op; in_a = a; in_b = b; in_dst = d; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    for (int t = 0; t < 200; t++) begin
      stall_seed++;
      out_ready = (stall_seed % 3) != 0;
      #1;
      if (prev_stall)
        check(out_valid && out_slot == ps && out_data == pv, "R2", "stalled token held",
              out_data, pv);
      if (out_valid && first < 0) first = cyc;
      if (out_valid && out_ready) begin
        if (got < 8) begin gs[got] = out_slot; gv[got] = out_data; end
        got++;
      end
      prev_stall = out_valid && !out_ready;
      ps = out_slot; pv = out_data;
      if (in_ready) begin fin = 1; break; end
      @(negedge clk);
      cyc++;
    end
    check(fin, req, "operation completes", 32'(cyc), 32'd0);
    check(got == ne, req, "token count", 32'(got), 32'(ne));
    for (int k = 0; k < ne && k < got && k < 8; k++) begin
      check(gs[k] == es[k], req, "token slot", {26'd0, gs[k]}, {26'd0, es[k]});
      check(gv[k] == ev[k], req, "token value", gv[k], ev[k]);
    end
    if (op == 20 && ne > 0) check(first == 32, "R6", "divide latency", 32'(first), 32'd32);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [4:0] ar_ops [6] = '{5'd17, 5'd18, 5'd19, 5'd28, 5'd29, 5'd30};
    string      ar_req [6] = '{"R3", "R4", "R5", "R7", "R7", "R7"};
    repeat (3) @(posedge clk);
    #1;
    check(in_ready === 1'b1, "R1", "reset in_ready", {31'd0, in_ready}, 32'd1);
    check(out_valid === 1'b0, "R1", "reset out_valid", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1;
    #1;
    check(in_ready === 1'b1 && out_valid === 1'b0, "R1", "idle after reset",
          {30'd0, in_ready, out_valid}, 32'd2);

    for (int o = 0; o < 6; o++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          run_op(ar_ops[o], vals[i], vals[j],
                 {(i == j) ? 6'd0 : 6'(40 + j), 6'(20 + i), (j % 3 == 0) ? 6'd0 : 6'(10 + j), 6'(1 + i)},
                 ar_req[o]);

    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        run_op(5'd20, vals[i], vals[j], {6'(50 + j), 6'(30 + i), 6'd0, 6'(1 + i + j)}, "R6");

    for (int c = 0; c < 8; c++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          run_op(5'd16, vals[i], vals[j],
                 {6'(33 + c), 3'((c + 3) % 8), (i == 2) ? 6'd0 : 6'(17 + j), 6'(1 + c), 3'(c)}, "R8");

    for (int b = 0; b < 41; b++)
      for (int s = 0; s < 4; s++)
        for (int v = 0; v < 2; v++)
          run_op(5'd21, v ? 32'h80000001 : 32'hdeadbeef, 32'(b),
                 {6'(30 + s), 2'((s + 2) % 4), 6'(20 + s), 2'((s + 1) % 4), 6'(10 + s), 2'(s)}, "R9");

    for (int op = 0; op < 32; op++)
      if (!(op >= 16 && op <= 21) && !(op >= 28 && op <= 30))
        run_op(5'(op), 32'h1234, 32'h5678, {6'd4, 6'd3, 6'd2, 6'd1}, "R10");

    run_op(5'd17, 32'h7fffffff, 32'h1, 24'd0, "R2");
    run_op(5'd20, 32'hcafef00d, 32'h0, {6'd9, 6'd8, 6'd7, 6'd6}, "R6");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule